// File: doc/BRIEF.md
# Port Spanning-Tree State Controller

This block holds a two-bit forwarding state for each of up to `NPORTS` switch ports. The host posts state-change requests at any time. Each request is only recorded: the block stores the wanted state for that port and marks the port as pending. A sequencer then works through the pending ports one at a time and commits their states, always taking the lowest-numbered pending port first.

Some changes move a port down from an active state (learning or forwarding) to a quiet one (blocking or disabled). Before such a change is committed, the sequencer asks an external address-table agent to flush that port's database identifier. It offers the request with a valid/ready handshake and then waits for a one-cycle completion pulse. The state register changes only after that pulse, so the address table never keeps entries learned under the old state once the new state is in force. Each port's 4-bit database identifier is a static input to the block.

Top module: `stp_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every port reads disabled and `flush_valid` is low.
- R2: Port p's state appears on `state_vec[2p+1:2p]`, encoded as 0 = disabled, 1 = blocking, 2 = learning, 3 = forwarding.
- R3: `req_code` maps as follows: 0 gives disabled; 1 (listening) and 2 both give blocking; 3 gives learning; 4 gives forwarding; every other value (5 to 7) gives forwarding.
- R4: A request is sampled on the clock edge where `req_valid` is high. The port's state is unchanged right after that edge. At the earliest, it changes on the following edge.
- R5: When several ports are pending, they are committed one pick at a time in ascending port order, whatever order the requests arrived in.
- R6: A second request for a port that is still pending replaces the stored target, and only the latest target is committed.
- R7: If the target equals the port's current state, no state is written and no flush is requested.
- R8: If the old state is learning or forwarding and the new state is blocking or disabled, the block does the following in order. It raises `flush_valid` with `flush_id` = `db_id_vec[4p+3:4p]`, and holds both steady until `flush_ready`. It then waits for `flush_done`. It writes the new state on the edge where `flush_done` is seen, and the state does not change before that edge.
- R9: All other state changes, whether upward or within the quiet pair (disabled and blocking) or within the active pair (learning and forwarding), are committed with no flush request.
- R10: A request for a port that arrives in the same cycle as the sequencer takes that port's pending bit leaves the bit set. The new target is committed by a later pick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A state-change request is present this cycle |
| req_port | input | PW ($clog2(NPORTS)) | Port the request targets |
| req_code | input | 3 | Requested state code (see R3) |
| db_id_vec | input | NPORTS*4 | Per-port address-database identifiers, port p at bits 4p+3:4p |
| flush_valid | output | 1 | Flush request offered |
| flush_id | output | 4 | Database identifier to flush |
| flush_ready | input | 1 | Flush request accepted this cycle |
| flush_done | input | 1 | One-cycle pulse: flush finished |
| state_vec | output | NPORTS*2 | Current state of every port (see R2) |

## Verification
Two functions can land on the same cycle: a host request setting a port's pending bit, and the sequencer clearing that same bit while it picks the port. The bench provokes this by posting two requests for one idle port on consecutive cycles, so the second arrives exactly on the pick edge of the first. The scoreboard then expects two separate commits for that port, the intermediate state first and then the final one. If the clear were allowed to win, the final commit would be missing and the scoreboard would report it.

// File: rtl/stp_ctrl_pkg.sv
package stp_ctrl_pkg;

    localparam int REQ_W = 3;

    typedef enum logic [1:0] {
        PS_DISABLED   = 2'd0,
        PS_BLOCKING   = 2'd1,
        PS_LEARNING   = 2'd2,
        PS_FORWARDING = 2'd3
    } pstate_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_OFFER = 2'd1,
        SQ_AWAIT = 2'd2
    } seq_e;

    // Host request code to committed state; listening folds into blocking.
    function automatic pstate_e decode_req(input logic [REQ_W-1:0] code);
        pstate_e s;
        case (code)
            3'd0:       s = PS_DISABLED;
            3'd1, 3'd2: s = PS_BLOCKING;
            3'd3:       s = PS_LEARNING;
            default:    s = PS_FORWARDING;
        endcase
        return s;
    endfunction

    // A drop from an active state into a quiet one needs a database flush.
    function automatic logic flush_needed(input pstate_e old_s, input pstate_e new_s);
        return (old_s >= PS_LEARNING) && (new_s <= PS_BLOCKING);
    endfunction

endpackage

// File: rtl/stp_lowest_pick.sv
module stp_lowest_pick #(
    parameter int N  = 8,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  mask,
    output logic [N-1:0]  grant,
    output logic [PW-1:0] idx,
    output logic          any
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar gi = 0; gi < N; gi++) begin : g_chain
            assign grant[gi]    = mask[gi] & ~seen[gi];
            assign seen[gi + 1] = seen[gi] | mask[gi];
        end
    endgenerate

    assign any = seen[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = PW'(i);
        end
    end

    // R5: exactly one grant, and nothing pending below it
    p_lowest_only_r5: assert property (@(posedge clk) disable iff (rst)
        any |-> ($countones(grant) == 1) && (((grant - 1'b1) & mask) == '0));

endmodule

// File: rtl/stp_req_store.sv
module stp_req_store
    import stp_ctrl_pkg::*;
#(
    parameter int N  = 8,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [PW-1:0]        req_port,
    input  logic [REQ_W-1:0]     req_code,
    input  logic [N-1:0]         clr_mask,
    output logic [N-1:0]         pending,
    output pstate_e [N-1:0]      target
);
    logic [N-1:0] set_mask;

    always_comb begin
        set_mask = '0;
        for (int i = 0; i < N; i++) begin
            if (req_valid && (req_port == PW'(i))) set_mask[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            for (int i = 0; i < N; i++) target[i] <= PS_DISABLED;
        end else begin
            // a fresh request wins over a same-cycle clear
            pending <= (pending & ~clr_mask) | set_mask;
            for (int i = 0; i < N; i++) begin
                if (set_mask[i]) target[i] <= decode_req(req_code);
            end
        end
    end

    // R6 / R10: a posted port is pending on the next cycle, even if picked now
    p_req_pending_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> pending[$past(req_port)]);

endmodule

// File: rtl/stp_state_bank.sv
module stp_state_bank
    import stp_ctrl_pkg::*;
#(
    parameter int N  = 8,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [PW-1:0]   wr_port,
    input  pstate_e         wr_val,
    output pstate_e [N-1:0] cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) cur[i] <= PS_DISABLED;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (wr_en && (wr_port == PW'(i))) cur[i] <= wr_val;
            end
        end
    end

    // R7: the sequencer never writes a value the port already holds
    p_real_change_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_val != cur[wr_port]));

endmodule

// File: rtl/stp_drain_seq.sv
module stp_drain_seq
    import stp_ctrl_pkg::*;
#(
    parameter int N   = 8,
    parameter int IDW = 4,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     pending,
    input  pstate_e [N-1:0]  target,
    input  pstate_e [N-1:0]  cur,
    input  logic [N*IDW-1:0] db_ids,
    output logic [N-1:0]     clr_mask,
    output logic             wr_en,
    output logic [PW-1:0]    wr_port,
    output pstate_e          wr_val,
    output logic             flush_valid,
    output logic [IDW-1:0]   flush_id,
    input  logic             flush_ready,
    input  logic             flush_done,
    output logic             in_flush
);
    seq_e          st_q, st_d;
    logic [N-1:0]  grant;
    logic [PW-1:0] pick_idx;
    logic          pick_any;
    pstate_e       pick_new, pick_old;
    logic          start_flush;
    logic [PW-1:0] sel_port_q;
    pstate_e       sel_state_q;
    logic [IDW-1:0] id_q;

    stp_lowest_pick #(.N(N)) u_pick (
        .clk   (clk),
        .rst   (rst),
        .mask  (pending),
        .grant (grant),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    assign pick_new = target[pick_idx];
    assign pick_old = cur[pick_idx];

    always_comb begin
        st_d        = st_q;
        clr_mask    = '0;
        wr_en       = 1'b0;
        wr_port     = '0;
        wr_val      = PS_DISABLED;
        start_flush = 1'b0;
        case (st_q)
            SQ_IDLE: begin
                if (pick_any) begin
                    clr_mask = grant;
                    if (pick_new != pick_old) begin
                        if (flush_needed(pick_old, pick_new)) begin
                            start_flush = 1'b1;
                            st_d        = SQ_OFFER;
                        end else begin
                            wr_en   = 1'b1;
                            wr_port = pick_idx;
                            wr_val  = pick_new;
                        end
                    end
                end
            end
            SQ_OFFER: begin
                if (flush_ready) st_d = SQ_AWAIT;
            end
            SQ_AWAIT: begin
                if (flush_done) begin
                    wr_en   = 1'b1;
                    wr_port = sel_port_q;
                    wr_val  = sel_state_q;
                    st_d    = SQ_IDLE;
                end
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= SQ_IDLE;
            sel_port_q  <= '0;
            sel_state_q <= PS_DISABLED;
            id_q        <= '0;
        end else begin
            st_q <= st_d;
            if (start_flush) begin
                sel_port_q  <= pick_idx;
                sel_state_q <= pick_new;
                id_q        <= db_ids[int'(pick_idx)*IDW +: IDW];
            end
        end
    end

    assign flush_valid = (st_q == SQ_OFFER);
    assign flush_id    = id_q;
    assign in_flush    = (st_q != SQ_IDLE);

    // R8: an offered flush stays up with a steady identifier until taken
    p_offer_hold_r8: assert property (@(posedge clk) disable iff (rst)
        flush_valid && !flush_ready |=> flush_valid && $stable(flush_id));

    // R5: at most one pending bit is taken per cycle
    p_single_take_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_mask));

endmodule

// File: rtl/stp_ctrl.sv
module stp_ctrl
    import stp_ctrl_pkg::*;
#(
    parameter int NPORTS = 8,
    parameter int IDW    = 4,
    localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [PW-1:0]         req_port,
    input  logic [REQ_W-1:0]      req_code,
    input  logic [NPORTS*IDW-1:0] db_id_vec,
    output logic                  flush_valid,
    output logic [IDW-1:0]        flush_id,
    input  logic                  flush_ready,
    input  logic                  flush_done,
    output logic [2*NPORTS-1:0]   state_vec
);
    logic [NPORTS-1:0]    pending;
    logic [NPORTS-1:0]    clr_mask;
    pstate_e [NPORTS-1:0] target;
    pstate_e [NPORTS-1:0] cur;
    logic                 wr_en;
    logic [PW-1:0]        wr_port;
    pstate_e              wr_val;
    logic                 in_flush;

    stp_req_store #(.N(NPORTS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_port  (req_port),
        .req_code  (req_code),
        .clr_mask  (clr_mask),
        .pending   (pending),
        .target    (target)
    );

    stp_drain_seq #(.N(NPORTS), .IDW(IDW)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .pending     (pending),
        .target      (target),
        .cur         (cur),
        .db_ids      (db_id_vec),
        .clr_mask    (clr_mask),
        .wr_en       (wr_en),
        .wr_port     (wr_port),
        .wr_val      (wr_val),
        .flush_valid (flush_valid),
        .flush_id    (flush_id),
        .flush_ready (flush_ready),
        .flush_done  (flush_done),
        .in_flush    (in_flush)
    );

    stp_state_bank #(.N(NPORTS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_port (wr_port),
        .wr_val  (wr_val),
        .cur     (cur)
    );

    generate
        for (genvar gp = 0; gp < NPORTS; gp++) begin : g_out
            assign state_vec[2*gp +: 2] = cur[gp];
        end
    endgenerate

    // R8: no state moves while a flush is outstanding and not yet done
    p_frozen_in_flush_r8: assert property (@(posedge clk) disable iff (rst)
        in_flush && !flush_done |=> $stable(state_vec));

endmodule

// File: tb/stp_ctrl_tb.sv
`timescale 1ns/1ps
module stp_ctrl_tb;
    localparam int NP  = 8;
    localparam int PWB = 3;
    localparam int IDB = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [PWB-1:0]    req_port = '0;
    logic [2:0]        req_code = '0;
    logic [NP*IDB-1:0] db_id_vec;
    logic              flush_valid;
    logic [IDB-1:0]    flush_id;
    logic              flush_ready = 1'b0;
    logic              flush_done = 1'b0;
    logic [2*NP-1:0]   state_vec;

    always #10 clk = ~clk;

    stp_ctrl #(.NPORTS(NP), .IDW(IDB)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_port    (req_port),
        .req_code    (req_code),
        .db_id_vec   (db_id_vec),
        .flush_valid (flush_valid),
        .flush_id    (flush_id),
        .flush_ready (flush_ready),
        .flush_done  (flush_done),
        .state_vec   (state_vec)
    );

    typedef struct {
        bit    fl;
        int    port;
        int    val;
        string tag;
    } ev_t;

    ev_t q[$];
    int  checks = 0;
    int  fails = 0;
    int  rdy_dly = 0;
    int  done_dly = 0;
    bit  ended = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int st_of(input int p);
        return int'(state_vec[2*p +: 2]);
    endfunction

    function automatic int dbid(input int p);
        return (3*p + 1) & 15;
    endfunction

    task automatic exp_state(input int p, input int v, input string tag);
        ev_t e;
        e.fl = 1'b0; e.port = p; e.val = v; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic exp_flush(input int id, input string tag);
        ev_t e;
        e.fl = 1'b1; e.port = 0; e.val = id; e.tag = tag;
        q.push_back(e);
    endtask

    // scoreboard compare of one observed event
    task automatic take(input bit fl, input int port, input int val);
        ev_t e;
        if (q.size() == 0) begin
            chk(1'b0, "R9", $sformatf("unexpected event kind=%0d port=%0d", fl, port), val, -1);
        end else begin
            e = q.pop_front();
            chk(e.fl == fl && e.port == port && e.val == val, e.tag,
                $sformatf("event kind=%0d port=%0d vs kind=%0d port=%0d",
                          fl, port, e.fl, e.port), val, e.val);
        end
    endtask

    task automatic post(input int p, input int c);
        req_port  = PWB'(p);
        req_code  = 3'(c);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (30) @(negedge clk);
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
    endtask

    // monitor: state commits
    initial begin
        logic [2*NP-1:0] prev;
        @(negedge clk);
        while (rst) @(negedge clk);
        prev = state_vec;
        forever begin
            @(negedge clk);
            if (state_vec != prev) begin
                for (int i = 0; i < NP; i++) begin
                    if (state_vec[2*i +: 2] != prev[2*i +: 2]) take(1'b0, i, st_of(i));
                end
            end
            prev = state_vec;
        end
    end

    // flush agent and monitor of flush handshakes
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && flush_valid) begin
                repeat (rdy_dly) @(negedge clk);
                flush_ready = 1'b1;
                take(1'b1, 0, int'(flush_id));
                @(negedge clk);
                flush_ready = 1'b0;
                repeat (done_dly) @(negedge clk);
                flush_done = 1'b1;
                @(negedge clk);
                flush_done = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) db_id_vec[IDB*i +: IDB] = IDB'(dbid(i));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        chk(state_vec == '0, "R1", "all ports disabled after reset", int'(state_vec), 0);
        chk(flush_valid == 1'b0, "R1", "no flush after reset", int'(flush_valid), 0);

        // R4 / R2: deferral and encoding
        exp_state(3, 3, "R4");
        post(3, 4);
        chk(st_of(3) == 0, "R4", "state unchanged right after request", st_of(3), 0);
        @(negedge clk);
        chk(st_of(3) == 3, "R2", "forwarding encoded as 3", st_of(3), 3);
        drain();

        // R8 / R3: forwarding -> listening flushes, lands in blocking
        exp_flush(dbid(3), "R8");
        exp_state(3, 1, "R3");
        post(3, 1);
        drain();

        // R7: blocking -> blocking does nothing
        post(3, 2);
        drain();
        chk(st_of(3) == 1, "R7", "same-state request leaves blocking", st_of(3), 1);

        // R3: unknown code gives forwarding
        exp_state(5, 3, "R3");
        post(5, 7);
        drain();

        // R5: ordering while the sequencer is held in a slow flush
        exp_state(3, 3, "R9");
        post(3, 4);
        drain();
        rdy_dly = 8;
        exp_flush(dbid(3), "R8");
        exp_state(3, 0, "R8");
        exp_state(1, 2, "R5");
        exp_state(4, 2, "R5");
        exp_state(6, 2, "R5");
        post(3, 0);
        post(6, 3);
        post(1, 3);
        post(4, 3);
        drain();

        // R6: overwrite of a pending target
        exp_flush(dbid(6), "R8");
        exp_state(6, 0, "R8");
        exp_state(2, 3, "R6");
        post(6, 0);
        post(2, 3);
        post(2, 4);
        drain();
        chk(st_of(2) == 3, "R6", "latest target committed", st_of(2), 3);

        // R8 / R9 with a prompt flush agent
        rdy_dly = 0;
        done_dly = 0;
        exp_flush(dbid(1), "R8");
        exp_state(1, 0, "R8");
        post(1, 0);
        drain();
        exp_state(4, 3, "R9");
        post(4, 4);
        drain();
        exp_state(5, 2, "R9");
        post(5, 3);
        drain();
        exp_state(0, 1, "R9");
        post(0, 2);
        drain();

        // R7: listening onto blocking, code 5 onto forwarding
        post(0, 1);
        post(4, 5);
        drain();
        chk(st_of(0) == 1, "R7", "port 0 stays blocking", st_of(0), 1);
        chk(st_of(4) == 3, "R7", "port 4 stays forwarding", st_of(4), 3);

        // R10: second request lands on the pick edge of the first
        exp_state(7, 1, "R10");
        exp_state(7, 3, "R10");
        post(7, 2);
        post(7, 4);
        drain();
        chk(st_of(7) == 3, "R10", "late request committed", st_of(7), 3);

        chk(q.size() == 0, "R5", "all expected events observed", q.size(), 0);
        summary();
        $finish;
    end

endmodule